// File: doc/BRIEF.md
# I2C Master Byte Queue Front-End

This block holds the two byte queues that sit between a processor and an I2C master bus engine. Software places outgoing bytes into a transmit queue by writing a data register. It takes incoming bytes from a receive queue by reading another data register. A status word reports both fill levels, a receive-not-empty flag, a transmit-full flag and a sticky error flag for a slave that did not acknowledge. A control register holds the acknowledge-ignore policy and one flush request per queue.

The bus engine sees a pop handshake on the transmit side and a push handshake on the receive side. It also has an input that reports a missing acknowledge. A flush empties its queue at once and then keeps the queue locked for a fixed number of cycles. While the lock holds, the flush request bit reads back as 1, so software can poll the bit until it clears.

Top module: `i2c_fifo_front`

## Requirements
- R1: A register write to address 0 (transmit data) appends byte `reg_wdata[7:0]` to the transmit queue when it is not full. The engine sees the oldest byte on `eng_tx_byte`, with `eng_tx_ready` high whenever the queue holds a byte. `eng_tx_pop` removes that byte on the clock edge. Status bits 23:16 give the transmit level, from 0 to DEPTH.
- R2: With DEPTH bytes queued, status bit 5 reads 1, and a transmit write is dropped. This holds even when the engine pops in the same cycle.
- R3: A read of address 1 (receive data) returns the oldest received byte in bits 7:0 and removes it. On an empty queue the read returns 0 and leaves the queue unchanged. Status bit 2 reads 1 while the receive queue is not empty, and status bits 15:8 give the receive level.
- R4: `eng_rx_push` appends `eng_rx_byte` to the receive queue. `eng_rx_room` is low while the queue is full or flushing, and a push at that time is dropped.
- R5: A write to address 2 (control) with bit 1 set flushes the receive queue, and with bit 2 set flushes the transmit queue. The queue reads empty from the next cycle. The bit reads back 1 for FLUSH_CYCLES cycles and then clears by itself, and only once the queue is empty. Pushes and pops during that time are ignored, and a new request restarts the count.
- R6: Status bit 1 is set when `eng_nack` is high while the ignore policy is off. The bit stays set until a status write (address 3) has bit 1 set. If a set and a clear happen in the same cycle, the set wins.
- R7: Control bit 0 is the acknowledge-ignore policy. It is written on every control write and output on `eng_nack_ignore`. While it is 1, `eng_nack` neither sets the error flag nor raises `eng_nack_abort`. While it is 0, `eng_nack_abort` follows `eng_nack` in the same cycle.
- R8: After reset both queues are empty and all status and control bits read 0.
- R9: Reads of address 0 return 0. Writes to address 1 have no effect. Control reads return only bit 0 (policy), bit 1 (receive flush busy) and bit 2 (transmit flush busy).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 1) |
| reg_addr | input | 2 | Register select: 0 tx data, 1 rx data, 2 control, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| eng_tx_pop | input | 1 | Engine takes the head transmit byte |
| eng_tx_byte | output | 8 | Head transmit byte, 0 when empty |
| eng_tx_ready | output | 1 | Transmit queue holds a byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_room | output | 1 | Receive queue can accept a byte |
| eng_nack | input | 1 | Slave did not acknowledge |
| eng_nack_ignore | output | 1 | Acknowledge-ignore policy |
| eng_nack_abort | output | 1 | Missing acknowledge ends the transfer |

## Verification
The bench targets these corner cases:
- A queue filled to exactly DEPTH, then written and popped in the same cycle. A design that lets the write through reports a level of 17 or overwrites the head byte.
- A read of an empty receive queue. A wrong design returns stale data or moves its pointers, and later bytes then come out in the wrong order.
- Flush requests issued while the queue is full and while pushes keep arriving. A design that clears the busy bit early, or accepts bytes during the lock, shows a level above 0 or a control bit that drops after the wrong number of cycles.
- A missing-acknowledge event arriving together with a clear write, and again under the ignore policy. This exposes a flag that loses the race, or an abort raised against the policy.

// File: rtl/ififo_pkg.sv
package ififo_pkg;
  localparam int REG_W      = 32;
  localparam int REG_SEL_W  = 2;
  localparam int BYTE_W     = 8;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_TXDATA = 2'd0,
    SEL_RXDATA = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int CTRL_IGN_BIT  = 0;
  localparam int CTRL_RXFL_BIT = 1;
  localparam int CTRL_TXFL_BIT = 2;

  localparam int ST_NACK_BIT   = 1;
  localparam int ST_RXNE_BIT   = 2;
  localparam int ST_TXFULL_BIT = 5;
  localparam int ST_RXLVL_LSB  = 8;
  localparam int ST_TXLVL_LSB  = 16;
  localparam int ST_LVL_W      = 8;
endpackage

// File: rtl/ififo_rst_sync.sv
module ififo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ififo_byte_queue.sv
// Circular byte store; DEPTH must be a power of two.
module ififo_byte_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [PW-1:0]    level,
  output logic             full,
  output logic             empty
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             do_push, do_pop;

  assign level = wptr_q - rptr_q;
  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);

  assign do_push = push && !full  && !flush;
  assign do_pop  = pop  && !empty && !flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (do_push) wptr_d = wptr_q + PW'(1);
      if (do_pop)  rptr_d = rptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q[AW-1:0]] <= push_data;
  end

  assign head = empty ? '0 : mem_q[rptr_q[AW-1:0]];
endmodule

// File: rtl/ififo_flush_seq.sv
// Holds a queue in flush for HOLD cycles after a request (HOLD >= 1).
module ififo_flush_seq #(
  parameter int HOLD = 4,
  localparam int CW   = (HOLD > 1) ? $clog2(HOLD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic drained,
  output logic busy
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(HOLD - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (drained) busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/i2c_fifo_front.sv
module i2c_fifo_front
  import ififo_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_SEL_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 eng_tx_pop,
  output logic [BYTE_W-1:0]    eng_tx_byte,
  output logic                 eng_tx_ready,
  input  logic                 eng_rx_push,
  input  logic [BYTE_W-1:0]    eng_rx_byte,
  output logic                 eng_rx_room,
  input  logic                 eng_nack,
  output logic                 eng_nack_ignore,
  output logic                 eng_nack_abort
);
  localparam int LVL_W = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1;

  logic rst_q_n;

  ififo_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // register decode
  logic wr_tx, rd_rx, wr_ctrl, wr_st;
  assign wr_tx   = reg_wr && (reg_addr == SEL_TXDATA);
  assign rd_rx   = reg_rd && (reg_addr == SEL_RXDATA);
  assign wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
  assign wr_st   = reg_wr && (reg_addr == SEL_STATUS);

  logic tx_go, rx_go;
  assign tx_go = wr_ctrl && reg_wdata[CTRL_TXFL_BIT];
  assign rx_go = wr_ctrl && reg_wdata[CTRL_RXFL_BIT];

  // queues and flush sequencers
  logic [BYTE_W-1:0] tx_head, rx_head;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_busy, rx_busy;

  ififo_flush_seq #(.HOLD(FLUSH_CYCLES)) u_tx_flush (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start   (tx_go),
    .drained (tx_empty),
    .busy    (tx_busy)
  );

  ififo_flush_seq #(.HOLD(FLUSH_CYCLES)) u_rx_flush (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start   (rx_go),
    .drained (rx_empty),
    .busy    (rx_busy)
  );

  ififo_byte_queue #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_txq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .flush     (tx_go || tx_busy),
    .push      (wr_tx),
    .push_data (reg_wdata),
    .pop       (eng_tx_pop),
    .head      (tx_head),
    .level     (tx_level),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  ififo_byte_queue #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .flush     (rx_go || rx_busy),
    .push      (eng_rx_push),
    .push_data (eng_rx_byte),
    .pop       (rd_rx),
    .head      (rx_head),
    .level     (rx_level),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  // policy and sticky error
  logic ign_q, ign_d, nack_q, nack_d, nack_set, nack_clr;

  assign nack_set = eng_nack && !ign_q;
  assign nack_clr = wr_st && reg_wdata[ST_NACK_BIT];

  always_comb begin
    ign_d  = wr_ctrl ? reg_wdata[CTRL_IGN_BIT] : ign_q;
    nack_d = nack_set || (nack_q && !nack_clr);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ign_q  <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      ign_q  <= ign_d;
      nack_q <= nack_d;
    end
  end

  // read side
  logic [REG_W-1:0] stat_word, ctrl_word;

  always_comb begin
    stat_word = '0;
    stat_word[ST_NACK_BIT]   = nack_q;
    stat_word[ST_RXNE_BIT]   = !rx_empty;
    stat_word[ST_TXFULL_BIT] = tx_full;
    stat_word[ST_RXLVL_LSB +: ST_LVL_W] = ST_LVL_W'(rx_level);
    stat_word[ST_TXLVL_LSB +: ST_LVL_W] = ST_LVL_W'(tx_level);
    ctrl_word = '0;
    ctrl_word[CTRL_IGN_BIT]  = ign_q;
    ctrl_word[CTRL_RXFL_BIT] = rx_busy;
    ctrl_word[CTRL_TXFL_BIT] = tx_busy;
  end

  always_comb begin
    case (reg_addr)
      SEL_RXDATA: reg_rdata = {{(REG_W-BYTE_W){1'b0}}, rx_head};
      SEL_CTRL:   reg_rdata = ctrl_word;
      SEL_STATUS: reg_rdata = stat_word;
      default:    reg_rdata = '0;
    endcase
  end

  assign eng_tx_byte     = tx_head;
  assign eng_tx_ready    = !tx_empty && !tx_busy;
  assign eng_rx_room     = !rx_full && !rx_busy;
  assign eng_nack_ignore = ign_q;
  assign eng_nack_abort  = nack_set;
endmodule

// File: rtl/i2c_fifo_front_chk.sv
module i2c_fifo_front_chk #(
  parameter int DEPTH = 16,
  localparam int LVL_W = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_busy,
  input logic             rx_busy,
  input logic             tx_go,
  input logic             rx_go,
  input logic             wr_tx,
  input logic             rd_rx,
  input logic             eng_tx_pop,
  input logic             eng_rx_push,
  input logic             eng_nack,
  input logic             ign_q,
  input logic             nack_q,
  input logic             nack_clr
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // R1
  tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= FULL_LVL);

  // R2
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == FULL_LVL && wr_tx && !eng_tx_pop && !tx_busy && !tx_go)
    |=> tx_level == FULL_LVL);

  // R3
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && rd_rx && !eng_rx_push && !rx_busy) |=> rx_level == '0);

  // R5
  tx_flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> (tx_level == '0 && tx_busy));

  // R5
  rx_flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_go |=> (rx_level == '0 && rx_busy));

  // R5
  rx_busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy) |-> rx_level == '0);

  // R6
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_q && !nack_clr) |=> nack_q);

  // R7
  nack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_nack && ign_q && !nack_q) |=> !nack_q);
endmodule

bind i2c_fifo_front i2c_fifo_front_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .tx_busy     (tx_busy),
  .rx_busy     (rx_busy),
  .tx_go       (tx_go),
  .rx_go       (rx_go),
  .wr_tx       (wr_tx),
  .rd_rx       (rd_rx),
  .eng_tx_pop  (eng_tx_pop),
  .eng_rx_push (eng_rx_push),
  .eng_nack    (eng_nack),
  .ign_q       (ign_q),
  .nack_q      (nack_q),
  .nack_clr    (nack_clr)
);

// File: tb/i2c_fifo_front_tb_top.sv
module i2c_fifo_front_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int DEPTH        = 16;
  localparam int FLUSH_CYCLES = 4;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [31:0] reg_rdata;
  logic        eng_tx_pop, eng_tx_ready, eng_rx_push, eng_rx_room;
  logic [7:0]  eng_tx_byte, eng_rx_byte;
  logic        eng_nack, eng_nack_ignore, eng_nack_abort;

  i2c_fifo_front #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_ready(eng_tx_ready),
    .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte), .eng_rx_room(eng_rx_room),
    .eng_nack(eng_nack), .eng_nack_ignore(eng_nack_ignore), .eng_nack_abort(eng_nack_abort)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit m_ign = 0, m_nack = 0, m_txb = 0, m_rxb = 0;
  int m_txc = 0, m_rxc = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd1: v = (rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
      2'd2: v = {29'h0, m_txb, m_rxb, m_ign};
      2'd3: begin
        v[1]     = m_nack;
        v[2]     = (rxq.size() > 0);
        v[5]     = (txq.size() == DEPTH);
        v[15:8]  = 8'(rxq.size());
        v[23:16] = 8'(txq.size());
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_step(bit wr, bit rd, logic [1:0] a, logic [7:0] wd,
                            bit tpop, bit rpush, logic [7:0] rb, bit nk);
    bit tx_go, rx_go;
    int n;
    tx_go = wr && a == 2'd2 && wd[2];
    rx_go = wr && a == 2'd2 && wd[1];
    if (tx_go || m_txb) txq.delete();
    else begin
      n = txq.size();
      if (tpop && n > 0) void'(txq.pop_front());
      if (wr && a == 2'd0 && n < DEPTH) txq.push_back(wd);
    end
    if (rx_go || m_rxb) rxq.delete();
    else begin
      n = rxq.size();
      if (rd && a == 2'd1 && n > 0) void'(rxq.pop_front());
      if (rpush && n < DEPTH) rxq.push_back(rb);
    end
    if (tx_go) begin m_txb = 1; m_txc = FLUSH_CYCLES - 1; end
    else if (m_txb) begin if (m_txc == 0) m_txb = 0; else m_txc--; end
    if (rx_go) begin m_rxb = 1; m_rxc = FLUSH_CYCLES - 1; end
    else if (m_rxb) begin if (m_rxc == 0) m_rxb = 0; else m_rxc--; end
    if (nk && !m_ign) m_nack = 1;
    else if (wr && a == 2'd3 && wd[1]) m_nack = 0;
    if (wr && a == 2'd2) m_ign = wd[0];
  endtask

  // one clock cycle; called at a falling edge
  task automatic cyc(bit wr, bit rd, logic [1:0] a, logic [7:0] wd,
                     bit tpop, bit rpush, logic [7:0] rb, bit nk, string rtag);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    eng_tx_pop = tpop; eng_rx_push = rpush; eng_rx_byte = rb; eng_nack = nk;
    #1;
    if (rd) chk(rtag, reg_rdata, exp_rdata(a));
    chk("R7", {31'h0, eng_nack_abort}, {31'h0, nk && !m_ign});
    @(posedge clk);
    model_step(wr, rd, a, wd, tpop, rpush, rb, nk);
    @(negedge clk);
    chk("R1", {24'h0, eng_tx_byte}, (txq.size() > 0) ? {24'h0, txq[0]} : 32'h0);
    chk("R1", {31'h0, eng_tx_ready}, {31'h0, txq.size() > 0 && !m_txb});
    chk("R4", {31'h0, eng_rx_room}, {31'h0, rxq.size() < DEPTH && !m_rxb});
    chk("R7", {31'h0, eng_nack_ignore}, {31'h0, m_ign});
  endtask

  task automatic idle(string tag);            cyc(0, 1, 2'd3, 8'h0, 0, 0, 8'h0, 0, tag); endtask
  task automatic wr_reg(logic [1:0] a, logic [7:0] d, string tag); cyc(1, 0, a, d, 0, 0, 8'h0, 0, tag); endtask
  task automatic rd_reg(logic [1:0] a, string tag); cyc(0, 1, a, 8'h0, 0, 0, 8'h0, 0, tag); endtask
  task automatic tx_pop(string tag);          cyc(0, 1, 2'd3, 8'h0, 1, 0, 8'h0, 0, tag); endtask
  task automatic rx_push(logic [7:0] b, string tag); cyc(0, 1, 2'd3, 8'h0, 0, 1, b, 0, tag); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_byte = 0; eng_nack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R8 reset state
    rd_reg(2'd0, "R8"); rd_reg(2'd1, "R8"); rd_reg(2'd2, "R8"); rd_reg(2'd3, "R8");

    // R1 ordering and level
    wr_reg(2'd0, 8'hA1, "R1"); wr_reg(2'd0, 8'hB2, "R1"); wr_reg(2'd0, 8'hC3, "R1");
    idle("R1");
    for (int i = 0; i < 4; i++) tx_pop("R1");

    // R2 fill past depth
    for (int i = 0; i < DEPTH + 1; i++) wr_reg(2'd0, 8'(i * 7 + 1), "R2");
    idle("R2");
    cyc(1, 0, 2'd0, 8'h5A, 1, 0, 8'h0, 0, "R2");
    idle("R2");
    for (int i = 0; i < DEPTH + 1; i++) tx_pop("R2");

    // R3 receive path and empty read
    for (int i = 0; i < 5; i++) rx_push(8'(8'h40 + i), "R3");
    for (int i = 0; i < 7; i++) rd_reg(2'd1, "R3");
    idle("R3");

    // R4 receive overflow
    for (int i = 0; i < DEPTH + 2; i++) rx_push(8'(8'h80 + i), "R4");
    idle("R4");

    // R5 receive flush under traffic
    wr_reg(2'd2, 8'h02, "R5");
    for (int i = 0; i < FLUSH_CYCLES + 2; i++) begin
      rd_reg(2'd2, "R5");
      rx_push(8'hEE, "R5");
    end
    idle("R5");
    // R5 transmit flush with pop in same cycle, writes during lock
    for (int i = 0; i < 3; i++) wr_reg(2'd0, 8'(8'h10 + i), "R5");
    cyc(1, 0, 2'd2, 8'h04, 1, 0, 8'h0, 0, "R5");
    for (int i = 0; i < FLUSH_CYCLES + 1; i++) begin
      wr_reg(2'd0, 8'h99, "R5");
      rd_reg(2'd2, "R5");
    end
    idle("R5");
    // R5 both bits, restart mid-lock
    wr_reg(2'd2, 8'h06, "R5"); rd_reg(2'd2, "R5");
    wr_reg(2'd2, 8'h02, "R5");
    for (int i = 0; i < FLUSH_CYCLES + 2; i++) rd_reg(2'd2, "R5");

    // R6 sticky error
    cyc(0, 1, 2'd3, 8'h0, 0, 0, 8'h0, 1, "R6");
    idle("R6"); idle("R6");
    wr_reg(2'd3, 8'hFD, "R6"); idle("R6");
    wr_reg(2'd3, 8'h02, "R6"); idle("R6");
    cyc(1, 0, 2'd3, 8'h02, 0, 0, 8'h0, 1, "R6");
    idle("R6");
    wr_reg(2'd3, 8'h02, "R6"); idle("R6");

    // R7 ignore policy
    wr_reg(2'd2, 8'h01, "R7"); rd_reg(2'd2, "R7");
    cyc(0, 1, 2'd3, 8'h0, 0, 0, 8'h0, 1, "R7");
    idle("R7");
    wr_reg(2'd2, 8'h00, "R7");
    cyc(0, 1, 2'd3, 8'h0, 0, 0, 8'h0, 1, "R7");
    idle("R7");
    wr_reg(2'd3, 8'h02, "R7");

    // R9 map: tx data reads zero, writes to rx data ignored
    wr_reg(2'd0, 8'h33, "R9"); rd_reg(2'd0, "R9");
    wr_reg(2'd1, 8'h77, "R9"); rd_reg(2'd3, "R9"); rd_reg(2'd1, "R9");
    rd_reg(2'd2, "R9");

    // mixed traffic
    for (int i = 0; i < 800; i++) begin
      int op;
      logic [1:0] a;
      string tg;
      op = int'($urandom_range(0, 99));
      a  = 2'($urandom_range(0, 3));
      tg = (a == 2'd0) ? "R9" : (a == 2'd1) ? "R3" : (a == 2'd2) ? "R5" : "R6";
      if (op < 3)
        cyc(1, 0, 2'd2, 8'($urandom_range(0, 7)), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, 8'($urandom), 0, "R5");
      else if (op < 40)
        cyc(1, 0, 2'd0, 8'($urandom), $urandom_range(0, 2) == 0,
            $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 30) == 0, "R1");
      else if (op < 45)
        cyc(1, 0, 2'd3, 8'($urandom), 0, 0, 8'h0, $urandom_range(0, 3) == 0, "R6");
      else
        cyc(0, 1, a, 8'h0, $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
            8'($urandom), $urandom_range(0, 30) == 0, tg);
    end

    done = 1;
    finish_run();
  end
endmodule